// File: doc/BRIEF.md
# Security-Banked Fault Register File

This block holds two fault registers of a system control coprocessor: the instruction fault status register and the fault address register. Each register has one copy for the secure world and one for the non-secure world. The coprocessor access path presents a register selector (opcode1, CRn, CRm, opcode2), a read/write flag, write data, the privilege level and the security state. The block answers in the same cycle with read data or an undefined-instruction flag. Writes take effect at the next rising clock edge.

Hardware events also write these registers, alongside software. A precise data abort or a watchpoint-triggered debug entry loads the fault address register. An instruction fault loads the status register. An external abort loads the status register as well; when the routing bit for external aborts is set, it always lands in the secure copy, because the abort takes the processor to the secure monitor. A hardware event that lands on the same copy as a software write in the same cycle wins over that write.

The reset input is asynchronous and active low. Its release is synchronized to the clock inside the block.

Top module: `fault_bank_regs`

## Requirements
- R1: After reset, all four register copies read as zero.
- R2: The fault address register is selected by opcode1=0, CRn=6, CRm=0, opcode2=0. The status register is selected by opcode1=0, CRn=5, CRm=0, opcode2=1. A privileged write stores the data exactly, and a later privileged read returns it.
- R3: A privileged access uses the copy of the current security state (`sec`=1 selects the secure copy, `sec`=0 the non-secure copy). A write in one state is not visible in the other.
- R4: Any access with `priv`=0 raises `undef`, returns zero read data and changes no register.
- R5: A privileged access with any other selector raises `undef` and changes no register.
- R6: A precise data abort loads its address into the fault address register copy of the current security state.
- R7: A watchpoint debug entry loads its address into the fault address register copy of the current state. If a data abort occurs in the same cycle, the abort address is stored.
- R8: An instruction fault loads its status into the status register copy of the current state.
- R9: With `cfg_ea_route`=1, an external abort writes the secure status copy whatever `sec` is. With `cfg_ea_route`=0, it writes the current-state copy. It beats an instruction fault aimed at the same copy.
- R10: A hardware update beats a software write to the same copy in the same cycle. A software write to a different copy in that cycle still takes effect.
- R11: `rd_data` and `undef` are combinational. `rd_data` is zero unless a privileged read hits a valid selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Coprocessor register access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | Opcode1 selector field |
| acc_crn | input | 4 | CRn selector field |
| acc_crm | input | 4 | CRm selector field |
| acc_op2 | input | 3 | Opcode2 selector field |
| acc_wdata | input | DATA_W | Write data |
| priv | input | 1 | 1 = privileged mode |
| sec | input | 1 | 1 = secure state |
| rd_data | output | DATA_W | Read data |
| undef | output | 1 | Undefined-instruction indication |
| dabort_valid | input | 1 | Precise data abort event |
| dabort_addr | input | DATA_W | Faulting virtual address |
| wpt_valid | input | 1 | Watchpoint debug entry event |
| wpt_addr | input | DATA_W | Watchpoint address |
| ifault_valid | input | 1 | Instruction fault event |
| ifault_status | input | DATA_W | Instruction fault status value |
| xabort_valid | input | 1 | External abort event |
| xabort_status | input | DATA_W | External abort status value |
| cfg_ea_route | input | 1 | External aborts routed to secure monitor |

## Verification
The bench targets bank crossings: a secure write must stay invisible from the non-secure state, and a routed external abort raised in non-secure state must land in the secure copy. A design that indexed by `sec` alone would fail the second case. It also collides events in the same cycle: abort against watchpoint, external abort against instruction fault, and hardware against software writes. A wrong priority would store the losing value. Finally, user-mode writes and near-miss selectors (one field off) are checked. A design that skipped the privilege check or decoded only part of the selector would corrupt a register or fail to flag `undef`.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int NREG     = 2;
  localparam int NBANK    = 2;
  localparam int REG_IFSR = 0;
  localparam int REG_FAR  = 1;
  localparam int BANK_NS  = 0;
  localparam int BANK_S   = 1;

  typedef struct packed {
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } cp_sel_t;

  localparam cp_sel_t SEL_IFSR = '{op1: 3'd0, crn: 4'd5, crm: 4'd0, op2: 3'd1};
  localparam cp_sel_t SEL_FAR  = '{op1: 3'd0, crn: 4'd6, crm: 4'd0, op2: 3'd0};
endpackage

// File: rtl/fault_rst_sync.sv
module fault_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fault_acc_decode.sv
module fault_acc_decode
  import fault_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  cp_sel_t         sel,
  input  logic            priv,
  output logic [NREG-1:0] hit,
  output logic [NREG-1:0] sw_we,
  output logic            rd_en,
  output logic            undef
);
  logic any_hit;

  always_comb begin
    hit           = '0;
    hit[REG_IFSR] = (sel == SEL_IFSR);
    hit[REG_FAR]  = (sel == SEL_FAR);
    any_hit       = |hit;
    undef         = acc_valid && (!priv || !any_hit);
    sw_we         = hit & {NREG{acc_valid && acc_write && priv}};
    rd_en         = acc_valid && !acc_write && priv && any_hit;
  end

  // R2: at most one register decoded
  p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_ni) $onehot0(hit));
  // R4: user mode never reaches a register
  p_user_trap_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_valid && !priv) |-> (undef && sw_we == '0 && !rd_en));
  // R5: undefined access never writes
  p_undef_nowr_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    undef |-> (sw_we == '0));
endmodule

// File: rtl/fault_bank_reg.sv
module fault_bank_reg
  import fault_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic [NBANK-1:0]       hw_we,
  input  logic [NBANK-1:0][W-1:0] hw_d,
  input  logic                   sw_we,
  input  logic                   sw_bank,
  input  logic [W-1:0]           sw_d,
  output logic [NBANK-1:0][W-1:0] q
);
  logic [NBANK-1:0]        en;
  logic [NBANK-1:0][W-1:0] d;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      if (hw_we[b]) begin
        en[b] = 1'b1;
        d[b]  = hw_d[b];
      end else if (sw_we && (int'(sw_bank) == b)) begin
        en[b] = 1'b1;
        d[b]  = sw_d;
      end else begin
        en[b] = 1'b0;
        d[b]  = q[b];
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)    q[b] <= '0;
      else if (en[b]) q[b] <= d[b];
    end

    // R10: hardware update beats software
    p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_ni)
      hw_we[b] |=> (q[b] == $past(hw_d[b])));
    // R4, R5: copy holds without a write
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
      (!hw_we[b] && !(sw_we && (int'(sw_bank) == b))) |=> $stable(q[b]));
  end
endmodule

// File: rtl/fault_bank_regs.sv
module fault_bank_regs
  import fault_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_op1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op2,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              priv,
  input  logic              sec,
  output logic [DATA_W-1:0] rd_data,
  output logic              undef,
  input  logic              dabort_valid,
  input  logic [DATA_W-1:0] dabort_addr,
  input  logic              wpt_valid,
  input  logic [DATA_W-1:0] wpt_addr,
  input  logic              ifault_valid,
  input  logic [DATA_W-1:0] ifault_status,
  input  logic              xabort_valid,
  input  logic [DATA_W-1:0] xabort_status,
  input  logic              cfg_ea_route
);
  logic                              rst_ni;
  cp_sel_t                           sel;
  logic [NREG-1:0]                   hit;
  logic [NREG-1:0]                   sw_we;
  logic                              rd_en;
  logic                              x_bank;
  logic [NREG-1:0][NBANK-1:0]        hw_we;
  logic [NREG-1:0][NBANK-1:0][DATA_W-1:0] hw_d;
  logic [NREG-1:0][NBANK-1:0][DATA_W-1:0] q_all;

  fault_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  assign sel = '{op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

  fault_acc_decode u_dec (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .sel       (sel),
    .priv      (priv),
    .hit       (hit),
    .sw_we     (sw_we),
    .rd_en     (rd_en),
    .undef     (undef)
  );

  assign x_bank = cfg_ea_route ? 1'b1 : sec;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      hw_we[REG_FAR][b] = (dabort_valid || wpt_valid) && (int'(sec) == b);
      hw_d[REG_FAR][b]  = dabort_valid ? dabort_addr : wpt_addr;
      if (xabort_valid && (int'(x_bank) == b)) begin
        hw_we[REG_IFSR][b] = 1'b1;
        hw_d[REG_IFSR][b]  = xabort_status;
      end else begin
        hw_we[REG_IFSR][b] = ifault_valid && (int'(sec) == b);
        hw_d[REG_IFSR][b]  = ifault_status;
      end
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    fault_bank_reg #(.W(DATA_W)) u_reg (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .hw_we   (hw_we[r]),
      .hw_d    (hw_d[r]),
      .sw_we   (sw_we[r]),
      .sw_bank (sec),
      .sw_d    (acc_wdata),
      .q       (q_all[r])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_en && hit[r]) rd_data = q_all[r][sec];
    end
  end

  // R11: no read data without a valid read
  p_rd_zero_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |-> (rd_data == '0));
  // R9: routed external abort lands in secure copy
  p_route_sec_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (xabort_valid && cfg_ea_route) |=> (q_all[REG_IFSR][BANK_S] == $past(xabort_status)));
  // R6: data abort loads current-state address copy
  p_abort_far_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    dabort_valid |=> (q_all[REG_FAR][$past(sec)] == $past(dabort_addr)));
  // R3: the opposite bank is untouched by an unrouted access path
  p_other_bank_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!dabort_valid && !wpt_valid && sec) |=> $stable(q_all[REG_FAR][BANK_NS]));
endmodule

// File: tb/fault_bank_regs_tb.sv
`timescale 1ns/1ps
module fault_bank_regs_tb_top;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_write, priv, sec;
  logic [2:0] acc_op1, acc_op2;
  logic [3:0] acc_crn, acc_crm;
  logic [W-1:0] acc_wdata, rd_data;
  logic undef;
  logic dabort_valid, wpt_valid, ifault_valid, xabort_valid, cfg_ea_route;
  logic [W-1:0] dabort_addr, wpt_addr, ifault_status, xabort_status;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fault_bank_regs #(.DATA_W(W)) dut_i (.*);

  typedef struct packed {
    logic [15:0] tag;
    logic s; logic pv; logic wr;
    logic [2:0] op1; logic [3:0] crn; logic [3:0] crm; logic [2:0] op2;
    logic [31:0] wd;
    logic ex_undef;
    logic [31:0] ex_rd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{"R1",1,1,0,0,6,0,0,32'h0,0,32'h0},          // secure FAR at reset
    '{"R1",0,1,0,0,5,0,1,32'h0,0,32'h0},          // ns IFSR at reset
    '{"R2",1,1,1,0,6,0,0,32'hA1A1_0001,0,32'h0},
    '{"R2",0,1,1,0,6,0,0,32'hB2B2_0002,0,32'h0},
    '{"R3",1,1,0,0,6,0,0,32'h0,0,32'hA1A1_0001},
    '{"R3",0,1,0,0,6,0,0,32'h0,0,32'hB2B2_0002},
    '{"R2",1,1,1,0,5,0,1,32'h0000_00C3,0,32'h0},
    '{"R3",0,1,0,0,5,0,1,32'h0,0,32'h0},
    '{"R3",1,1,0,0,5,0,1,32'h0,0,32'h0000_00C3},
    '{"R4",1,0,0,0,6,0,0,32'h0,1,32'h0},
    '{"R4",0,0,1,0,6,0,0,32'hFFFF_FFFF,1,32'h0},
    '{"R4",0,1,0,0,6,0,0,32'h0,0,32'hB2B2_0002},
    '{"R5",0,1,1,0,7,0,0,32'h1234_5678,1,32'h0},
    '{"R5",0,1,1,0,6,0,1,32'h1234_5678,1,32'h0},
    '{"R5",1,1,1,1,5,0,1,32'h1234_5678,1,32'h0},
    '{"R5",1,1,1,0,5,1,1,32'h1234_5678,1,32'h0},
    '{"R5",0,1,0,0,6,0,0,32'h0,0,32'hB2B2_0002},
    '{"R5",1,1,0,0,5,0,1,32'h0,0,32'h0000_00C3}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic s, input bit is_far, output logic [W-1:0] v);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; priv = 1; sec = s;
    acc_op1 = 0; acc_crm = 0;
    acc_crn = is_far ? 4'd6 : 4'd5;
    acc_op2 = is_far ? 3'd0 : 3'd1;
    #1 v = rd_data;
    acc_valid = 0;
  endtask

  task automatic idle_hw();
    dabort_valid = 0; wpt_valid = 0; ifault_valid = 0; xabort_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    acc_valid = 0; acc_write = 0; priv = 0; sec = 0;
    acc_op1 = 0; acc_op2 = 0; acc_crn = 0; acc_crm = 0; acc_wdata = 0;
    dabort_addr = 0; wpt_addr = 0; ifault_status = 0; xabort_status = 0;
    cfg_ea_route = 0;
    idle_hw();
    do_reset();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_valid = 1; sec = VEC[i].s; priv = VEC[i].pv; acc_write = VEC[i].wr;
      acc_op1 = VEC[i].op1; acc_crn = VEC[i].crn; acc_crm = VEC[i].crm;
      acc_op2 = VEC[i].op2; acc_wdata = VEC[i].wd;
      #1;
      chk({string'(VEC[i].tag), " undef"}, {31'b0, undef}, {31'b0, VEC[i].ex_undef});
      chk({string'(VEC[i].tag), " / R11 rd_data"}, rd_data, VEC[i].ex_rd);
    end
    @(negedge clk); acc_valid = 0; #1;
    chk("R11 idle rd_data", rd_data, 0);

    // R6: data abort in non-secure state
    @(negedge clk); sec = 0; dabort_valid = 1; dabort_addr = 32'h1000_0040;
    @(negedge clk); idle_hw();
    rd(0, 1, v); chk("R6 ns FAR", v, 32'h1000_0040);
    rd(1, 1, v); chk("R6 s FAR kept", v, 32'hA1A1_0001);

    // R7: watchpoint, then collision with abort
    @(negedge clk); sec = 1; wpt_valid = 1; wpt_addr = 32'h2000_0080;
    @(negedge clk); idle_hw();
    rd(1, 1, v); chk("R7 s FAR wpt", v, 32'h2000_0080);
    @(negedge clk); sec = 1; wpt_valid = 1; wpt_addr = 32'h4000_0100;
    dabort_valid = 1; dabort_addr = 32'h3000_00C0;
    @(negedge clk); idle_hw();
    rd(1, 1, v); chk("R7 abort beats wpt", v, 32'h3000_00C0);

    // R8: instruction fault
    @(negedge clk); sec = 0; ifault_valid = 1; ifault_status = 32'h0D;
    @(negedge clk); idle_hw();
    rd(0, 0, v); chk("R8 ns IFSR", v, 32'h0D);
    rd(1, 0, v); chk("R8 s IFSR kept", v, 32'hC3);

    // R9: routed and unrouted external aborts
    @(negedge clk); sec = 0; cfg_ea_route = 1; xabort_valid = 1; xabort_status = 32'h08;
    @(negedge clk); idle_hw(); cfg_ea_route = 0;
    rd(1, 0, v); chk("R9 routed to secure", v, 32'h08);
    rd(0, 0, v); chk("R9 ns untouched", v, 32'h0D);
    @(negedge clk); sec = 0; xabort_valid = 1; xabort_status = 32'h16;
    @(negedge clk); idle_hw();
    rd(0, 0, v); chk("R9 unrouted ns", v, 32'h16);
    @(negedge clk); sec = 1; xabort_valid = 1; xabort_status = 32'h406;
    ifault_valid = 1; ifault_status = 32'h99;
    @(negedge clk); idle_hw();
    rd(1, 0, v); chk("R9 xabort beats ifault", v, 32'h406);
    @(negedge clk); sec = 0; cfg_ea_route = 1; xabort_valid = 1; xabort_status = 32'h55;
    ifault_valid = 1; ifault_status = 32'h66;
    @(negedge clk); idle_hw(); cfg_ea_route = 0;
    rd(1, 0, v); chk("R9 routed split s", v, 32'h55);
    rd(0, 0, v); chk("R9 routed split ns", v, 32'h66);

    // R10: hardware versus software
    @(negedge clk); sec = 1; priv = 1; acc_valid = 1; acc_write = 1;
    acc_op1 = 0; acc_crn = 6; acc_crm = 0; acc_op2 = 0; acc_wdata = 32'hDEAD;
    dabort_valid = 1; dabort_addr = 32'h5000;
    @(negedge clk); idle_hw(); acc_valid = 0;
    rd(1, 1, v); chk("R10 hw beats sw", v, 32'h5000);
    @(negedge clk); sec = 1; priv = 1; acc_valid = 1; acc_write = 1;
    acc_op1 = 0; acc_crn = 5; acc_crm = 0; acc_op2 = 1; acc_wdata = 32'h77;
    dabort_valid = 1; dabort_addr = 32'h6000;
    @(negedge clk); idle_hw(); acc_valid = 0;
    rd(1, 0, v); chk("R10 sw other reg", v, 32'h77);
    rd(1, 1, v); chk("R10 hw same cycle", v, 32'h6000);

    // R1: reset mid-run clears all copies
    do_reset();
    rd(0, 0, v); chk("R1 ns IFSR", v, 0);
    rd(1, 0, v); chk("R1 s IFSR", v, 0);
    rd(0, 1, v); chk("R1 ns FAR", v, 0);
    rd(1, 1, v); chk("R1 s FAR", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule